// File: doc/BRIEF.md
# MDIO Management Master

This block is the master end of the two-wire management bus that links a MAC to an Ethernet PHY. A host strobes `start` with a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The master then builds the whole management frame by itself. It produces the management clock by counting system clocks per half-period, and it drives the data line through an output-enable so that the line can be released to the PHY.

The master counts time in bit periods. Each period has a low half and a high half, and each half lasts `half_div` system clocks. The master changes the data line only in the low half. Data from the PHY passes through a two-flop synchronizer and is sampled in the last system cycle of a high half. If the PHY does not pull the turnaround bit low during a read, the master abandons the read. It then clocks 32 idle periods with the line released so that the PHY can recover, and it reports an error. When any frame ends, `busy` drops, `done` pulses and the result is held steady until the next frame finishes.

Top module: `mdio_master`

## Requirements
- R1: Each frame begins with 32 bit periods in which `mdio_oe`=1 and `mdio_o`=1.
- R2: After the first 32 periods the master drives the start pattern 0 then 1 (periods 32 and 33). The opcode follows: 1,0 for a read (`rd_nwr`=1) and 0,1 for a write (periods 34 and 35).
- R3: Periods 36 to 40 carry the PHY address and periods 41 to 45 carry the register address, each field most significant bit first.
- R4: Each half of a bit period lasts H system clocks. H is `half_div` latched at start and raised to 3 when it is smaller. `mdc` is 0 in the low half and 1 in the high half, and `mdio_o`/`mdio_oe` change only at the start of a low half.
- R5: A write drives 1 then 0 in periods 46 and 47, then the 16 data bits MSB first in periods 48 to 63. Period 64 follows with `mdio_oe`=0, so a write frame is 65 periods long.
- R6: A read releases the line (`mdio_oe`=0) from period 46 onward. The line is sampled through two flops at the end of each high half. Period 46 is the turnaround and periods 47 to 62 carry the data bits MSB first. Two further periods follow, so the frame is 65 periods and `rd_data` takes the data at the end.
- R7: If the read turnaround sample is 1, the master sends 32 more released periods (79 in total), sets `err`=1 and sets `rd_data`=0. Any other frame ends with `err`=0, and a write leaves `rd_data` unchanged.
- R8: `busy` is 1 in the cycle after an accepted start. A start seen while `busy`=1 is ignored, including its address, data, flag and divider inputs.
- R9: `done` is a one-cycle pulse in the first cycle with `busy`=0 after a frame. `rd_data` and `err` change only in that cycle. A start given in the `done` cycle is accepted.
- R10: After reset and between frames `mdc`=0, `mdio_oe`=0, `busy`=0 and `done`=0. Reset clears `rd_data` and `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame when idle |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Value to write |
| half_div | input | DIV_W | System clocks per half bit period (minimum 3 applied) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data driven onto the line |
| mdio_oe | output | 1 | Drive enable for the line |
| mdio_i | input | 1 | Line level seen at the pad |
| rd_data | output | 16 | Last read result |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| err | output | 1 | Last read saw no PHY turnaround |

## Verification
Two events can fall in the same cycle: the end of one frame (`done`) and a new `start`. The bench tests this by raising `start` in the very cycle that `done` appears. Its reference model then expects the next frame's first low half at once, and it expects the previous result to stay visible while the new frame runs. The other overlap is a start that arrives in the middle of a frame with different inputs. The model expects the running frame to carry on unchanged, bit for bit and cycle for cycle.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rd_nwr,
  input  logic [4:0]       phy_addr,
  input  logic [4:0]       reg_addr,
  input  logic [15:0]      wr_data,
  input  logic [DIV_W-1:0] half_div,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i,
  output logic [15:0]      rd_data,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int PW = 7;
  localparam logic [PW-1:0] TA_PER   = PW'(46);
  localparam logic [PW-1:0] DATA_END = PW'(62);
  localparam logic [PW-1:0] LAST_OK  = PW'(64);
  localparam logic [PW-1:0] LAST_ERR = PW'(78);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(MIN_HALF);

  logic             rd_q, hi, abort;
  logic [4:0]       pa_q, ra_q;
  logic [15:0]      wd_q, shreg;
  logic [DIV_W-1:0] h_q, cnt, h_in;
  logic [PW-1:0]    per, nper, last;
  logic [1:0]       sync;
  logic             n_oe, n_o;
  logic [3:0]       widx;
  logic [2:0]       pidx, ridx;

  assign h_in = (half_div < MIN_DIV) ? MIN_DIV : half_div;
  assign nper = per + 1'b1;
  assign last = abort ? LAST_ERR : LAST_OK;
  assign widx = 4'(PW'(63) - nper);
  assign pidx = 3'(PW'(40) - nper);
  assign ridx = 3'(PW'(45) - nper);

  always_comb begin
    n_oe = 1'b1;
    n_o  = 1'b1;
    if (nper >= TA_PER) begin
      if (rd_q)                   begin n_oe = 1'b0; n_o = 1'b0; end
      else if (nper == PW'(47))   n_o = 1'b0;
      else if (nper > PW'(47) && nper <= PW'(63)) n_o = wd_q[widx];
      else if (nper > PW'(63))    begin n_oe = 1'b0; n_o = 1'b0; end
    end
    else if (nper >= PW'(41)) n_o = ra_q[ridx];
    else if (nper >= PW'(36)) n_o = pa_q[pidx];
    else if (nper == PW'(32)) n_o = 1'b0;
    else if (nper == PW'(34)) n_o = rd_q;
    else if (nper == PW'(35)) n_o = ~rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11; busy <= 1'b0; done <= 1'b0; err <= 1'b0;
      rd_data <= '0; shreg <= '0; mdc <= 1'b0; mdio_o <= 1'b0; mdio_oe <= 1'b0;
      rd_q <= 1'b0; pa_q <= '0; ra_q <= '0; wd_q <= '0; h_q <= MIN_DIV;
      cnt <= '0; per <= '0; hi <= 1'b0; abort <= 1'b0;
    end else begin
      sync <= {sync[0], mdio_i};
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; rd_q <= rd_nwr; pa_q <= phy_addr; ra_q <= reg_addr;
          wd_q <= wr_data; h_q <= h_in; cnt <= h_in - 1'b1;
          per <= '0; hi <= 1'b0; abort <= 1'b0;
          mdc <= 1'b0; mdio_oe <= 1'b1; mdio_o <= 1'b1;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= h_q - 1'b1;
        if (!hi) begin
          hi  <= 1'b1;
          mdc <= 1'b1;
        end else begin
          hi  <= 1'b0;
          mdc <= 1'b0;
          if (rd_q && per == TA_PER && sync[1]) abort <= 1'b1;
          if (rd_q && !abort && per > TA_PER && per <= DATA_END)
            shreg <= {shreg[14:0], sync[1]};
          if (per == last) begin
            busy <= 1'b0; done <= 1'b1; mdio_oe <= 1'b0; mdio_o <= 1'b0;
            if (rd_q) begin
              err     <= abort;
              rd_data <= abort ? 16'h0000 : shreg;
            end else begin
              err <= 1'b0;
            end
          end else begin
            per     <= nper;
            mdio_oe <= n_oe;
            mdio_o  <= n_o;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int MIN_HALF = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [15:0] rd_data,
  input logic        err
);
  logic       mdc_d;
  logic [7:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_d <= 1'b0;
      run   <= 8'd0;
    end else begin
      mdc_d <= mdc;
      if (mdc != mdc_d)     run <= 8'd1;
      else if (run != 8'hFF) run <= run + 8'd1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R10

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R9

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(rd_data) && $stable(err))); // R9

  AST_LINE_STILL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe))); // R4

  AST_HALF_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mdc != mdc_d) |-> (run >= 8'(MIN_HALF))); // R4
endmodule

bind mdio_master mdio_master_chk #(.MIN_HALF(MIN_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data), .err(err)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, rd_nwr = 1'b0, mdio_i = 1'b1;
  logic [4:0] phy_addr = '0, reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic [DIV_W-1:0] half_div = '0;
  logic mdc, mdio_o, mdio_oe, busy, done, err;
  logic [15:0] rd_data;

  int checks = 0, errors = 0;
  logic [15:0] exp_rd = '0;
  logic exp_err = 1'b0;
  bit fin = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .half_div(half_div), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i), .rd_data(rd_data), .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R10", {busy, done, mdc, mdio_oe}, 4'b0000);
      chk("R9", {err, rd_data}, {exp_err, exp_rd});
    end
  endtask

  // Called at a negedge; start is raised at once.
  task automatic run(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                     input logic [15:0] wd, input int div, input bit miss,
                     input logic [15:0] rdv, input bit poke);
    bit oeq[$]; bit oq[$]; bit inq[$];
    int h;
    string rq;
    h = (div < 3) ? 3 : div;
    for (int i = 0; i < 32; i++) begin oeq.push_back(1); oq.push_back(1); end
    oeq.push_back(1); oq.push_back(0);
    oeq.push_back(1); oq.push_back(1);
    oeq.push_back(1); oq.push_back(rd);
    oeq.push_back(1); oq.push_back(!rd);
    for (int i = 4; i >= 0; i--) begin oeq.push_back(1); oq.push_back(pa[i]); end
    for (int i = 4; i >= 0; i--) begin oeq.push_back(1); oq.push_back(ra[i]); end
    if (!rd) begin
      oeq.push_back(1); oq.push_back(1);
      oeq.push_back(1); oq.push_back(0);
      for (int i = 15; i >= 0; i--) begin oeq.push_back(1); oq.push_back(wd[i]); end
      oeq.push_back(0); oq.push_back(0);
    end else begin
      for (int i = 0; i < (miss ? 33 : 19); i++) begin oeq.push_back(0); oq.push_back(0); end
    end
    for (int k = 0; k < oeq.size(); k++) begin
      if (rd && k == 46) inq.push_back(miss);
      else if (rd && !miss && k >= 47 && k <= 62) inq.push_back(rdv[62-k]);
      else inq.push_back(1);
    end

    start = 1; rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
    half_div = DIV_W'(div);
    for (int k = 0; k < oeq.size(); k++)
      for (int hf = 0; hf < 2; hf++)
        for (int c = 0; c < h; c++) begin
          @(negedge clk);
          start = 0;
          if (hf == 0 && c == 0) mdio_i = inq[k];
          if (k < 32) rq = "R1";
          else if (k < 36) rq = "R2";
          else if (k < 46) rq = "R3";
          else rq = !rd ? "R5" : (miss ? "R7" : "R6");
          if (k == 0 && hf == 0 && c == 0) rq = "R8";
          if (poke && k > 10) rq = "R8";
          chk({rq, "/R4"}, {busy, done, mdc, mdio_oe, oeq[k] ? mdio_o : 1'b0},
              {1'b1, 1'b0, hf[0], oeq[k], oeq[k] ? oq[k] : 1'b0});
          chk("R9", {err, rd_data}, {exp_err, exp_rd});
          if (poke && k == 10 && hf == 0 && c == 0) begin
            start = 1; rd_nwr = !rd; phy_addr = ~pa; reg_addr = ~ra;
            wr_data = ~wd; half_div = DIV_W'(h + 2);
          end
        end
    @(negedge clk);
    mdio_i = 1;
    if (rd) begin exp_err = miss; exp_rd = miss ? 16'h0000 : rdv; end
    else exp_err = 0;
    chk("R9", {busy, done, mdc, mdio_oe}, 4'b0100);
    chk(!rd ? "R5" : (miss ? "R7" : "R6"), {err, rd_data}, {exp_err, exp_rd});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10", {busy, done, mdc, mdio_oe, err}, 5'b00000);
    chk("R10", rd_data, 16'h0000);
    idle(3);
    run(0, 5'h13, 5'h0A, 16'hA5C3, 3, 0, 16'h0, 0);
    idle(3);
    run(1, 5'h01, 5'h1F, 16'h0, 4, 0, 16'hBEEF, 0);
    idle(2);
    run(1, 5'h1E, 5'h05, 16'h0, 0, 1, 16'h0, 0);
    idle(2);
    run(0, 5'h0C, 5'h11, 16'h5A0F, 5, 0, 16'h0, 1);
    idle(2);
    run(1, 5'h10, 5'h01, 16'h0, 3, 0, 16'h8001, 0);
    run(0, 5'h07, 5'h18, 16'h0001, 1, 0, 16'h0, 0);
    idle(2);
    run(1, 5'h00, 5'h00, 16'h0, 3, 0, 16'h0000, 0);
    idle(4);
    fin = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual=busy%0b expected=finished", busy);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule